// File: doc/BRIEF.md
# ADC Output Formatter and Overrange Monitor

This block sits between the digital back end of a data converter and its parallel output pins. Each valid 16-bit two's-complement sample is re-coded into offset binary, two's complement or Gray code. The block also drives a data clock qualifier, whose active edge can be chosen, and an overrange flag. The flag is raised when the sample magnitude reaches a programmable digital trip level, or when the external analog-trip input is high for that sample.

An optional self-reset policy lets the overrange trigger a reset of the converter. A digital overrange starts the reset at once. An analog trip starts it only after 16 consecutive tripped samples. The reset lasts a fixed 8 samples. During that window the output word is forced to the midscale code of the selected format and the flag stays high. Configuration is written through a small parallel write port.

Top module: `adc_out_fmt`

## Requirements
- R1: After the asynchronous reset, data_o, ovr_o, dco_o and mod_rst_o are all 0. The configuration is then: format 0 (offset binary), rising polarity, threshold 0, auto-reset off.
- R2: The format field selects the output code. Code 0 gives offset binary, which is the sample with its MSB inverted. Codes 1 and 3 give two's complement, the sample unchanged. Code 2 gives Gray code, formed as offset binary XOR (offset binary >> 1).
- R3: data_o and ovr_o take the result for a sample one clock after sample_vld_i is high. They hold their value through cycles with no valid sample.
- R4: For threshold n, the trip level is 32767 - 512*n. The flag is set when |sample| >= level, with -32768 taken as magnitude 32768. At n = 0 a sample clipped at full scale trips.
- R5: A valid sample with atrip_i high sets ovr_o for that sample, whatever its magnitude.
- R6: With auto-reset off, mod_rst_o never rises and ovr_o follows each sample's result.
- R7: With auto-reset on, a digital overrange sample is output normally with ovr_o high, and mod_rst_o rises with it. The next 8 valid samples are output as the midscale code with ovr_o high: 0x8000 in offset binary, 0x0000 in two's complement, 0xC000 in Gray. mod_rst_o falls together with the 8th of these.
- R8: With auto-reset on, an analog trip starts the reset only on the 16th consecutive valid sample with atrip_i high. A valid sample without a trip clears the run.
- R9: dco_o is high for the one cycle after each valid sample while the polarity bit is 0. It is the inverse of that pulse while the polarity bit is 1.
- R10: When wr_en_i is high, address 0 writes the format from bits [1:0] and the polarity from bit 2. Address 1 writes the threshold from bits [5:0] and auto-reset enable from bit 7. Writes to addresses 2 and 3 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sample clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Register address |
| wr_data_i | input | 8 | Register write data |
| sample_i | input | 16 | Two's-complement sample |
| sample_vld_i | input | 1 | Sample valid |
| atrip_i | input | 1 | Analog trip flag for the current sample |
| data_o | output | 16 | Formatted output word |
| dco_o | output | 1 | Data clock qualifier |
| ovr_o | output | 1 | Overrange flag |
| mod_rst_o | output | 1 | Converter self-reset in progress |

## Verification
A vector table covers the coding, using zero, +1, -1, positive and negative full scale, and an arbitrary word. These values tell apart an inverted MSB, a missing Gray XOR, and the reserved format code. For the threshold, samples sit exactly at the trip level and one LSB below it, for both signs and at the extreme settings 0, 1 and 63. This separates >= from >, and a correct magnitude from a plain two's-complement compare. Directed runs cover several cases: 15 and then 16 consecutive analog trips separated by a clean sample, the 8-sample reset window in two formats, auto-reset off, inverted clock polarity, and writes to unused addresses.

// File: rtl/adc_fmt_pkg.sv
package adc_fmt_pkg;
  typedef enum logic [1:0] {
    FMT_OFFSET = 2'd0,
    FMT_TWOS   = 2'd1,
    FMT_GRAY   = 2'd2,
    FMT_TWOS_R = 2'd3
  } fmt_e;

  localparam int REG_AW   = 2;
  localparam int REG_DW   = 8;
  localparam int THR_W    = 6;
  localparam logic [REG_AW-1:0] ADDR_FMT = 2'd0;
  localparam logic [REG_AW-1:0] ADDR_OVR = 2'd1;
  localparam int POL_BIT  = 2;
  localparam int AREN_BIT = 7;
endpackage

// File: rtl/adc_fmt_regs.sv
module adc_fmt_regs
  import adc_fmt_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [REG_AW-1:0] wr_addr_i,
  input  logic [REG_DW-1:0] wr_data_i,
  output fmt_e              fmt_o,
  output logic              pol_o,
  output logic [THR_W-1:0]  thr_o,
  output logic              ar_en_o
);
  logic unused_wr;
  assign unused_wr = wr_data_i[6];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fmt_o <= FMT_OFFSET;
      pol_o <= 1'b0;
    end else if (wr_en_i && wr_addr_i == ADDR_FMT) begin
      fmt_o <= fmt_e'(wr_data_i[1:0]);
      pol_o <= wr_data_i[POL_BIT];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      thr_o   <= '0;
      ar_en_o <= 1'b0;
    end else if (wr_en_i && wr_addr_i == ADDR_OVR) begin
      thr_o   <= wr_data_i[THR_W-1:0];
      ar_en_o <= wr_data_i[AREN_BIT];
    end
  end

  assert_unmapped_write_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_addr_i != ADDR_FMT && wr_addr_i != ADDR_OVR)
      |=> ($stable(fmt_o) && $stable(pol_o) && $stable(thr_o) && $stable(ar_en_o)));

  assert_idle_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> ($stable(fmt_o) && $stable(thr_o) && $stable(ar_en_o)));
endmodule

// File: rtl/adc_fmt_code.sv
module adc_fmt_code
  import adc_fmt_pkg::*;
#(
  parameter int DW       = 16,
  parameter int STEP_LOG = 9
) (
  input  logic [DW-1:0]    sample_i,
  input  fmt_e             fmt_i,
  input  logic [THR_W-1:0] thr_i,
  output logic [DW-1:0]    code_o,
  output logic [DW-1:0]    mid_o,
  output logic             over_o
);
  localparam logic [DW:0]   FULL   = (DW+1)'((1 << (DW-1)) - 1);
  localparam logic [DW-1:0] OB_MID = DW'(1) << (DW-1);
  localparam logic [DW-1:0] GR_MID = OB_MID ^ (OB_MID >> 1);

  logic [DW-1:0] ob;
  logic [DW-1:0] gray;
  logic [DW:0]   mag;
  logic [DW:0]   level;

  assign ob = {~sample_i[DW-1], sample_i[DW-2:0]};

  assign gray[DW-1] = ob[DW-1];
  for (genvar i = 0; i < DW-1; i++) begin : g_gray
    assign gray[i] = ob[i] ^ ob[i+1];
  end

  always_comb begin
    unique case (fmt_i)
      FMT_OFFSET: begin code_o = ob;       mid_o = OB_MID; end
      FMT_GRAY:   begin code_o = gray;     mid_o = GR_MID; end
      default:    begin code_o = sample_i; mid_o = '0;     end
    endcase
  end

  // magnitude in DW+1 bits so that the most negative code maps to 2^(DW-1)
  assign mag    = sample_i[DW-1] ? ({1'b0, ~sample_i} + 1'b1) : {1'b0, sample_i};
  assign level  = FULL - ((DW+1)'(thr_i) << STEP_LOG);
  assign over_o = (mag >= level);

  always_comb begin
    assert_gray_msb_R2: assert (fmt_i != FMT_GRAY || code_o[DW-1] == ~sample_i[DW-1]);
  end
endmodule

// File: rtl/adc_ovr_ctrl.sv
module adc_ovr_ctrl #(
  parameter int TRIP_RUN = 16,
  parameter int RST_LEN  = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic vld_i,
  input  logic ar_en_i,
  input  logic dig_over_i,
  input  logic atrip_i,
  output logic busy_o,
  output logic flag_o
);
  localparam int TCW = $clog2(TRIP_RUN);
  localparam int RCW = $clog2(RST_LEN + 1);
  localparam logic [TCW-1:0] TRIP_LAST = TCW'(TRIP_RUN - 1);
  localparam logic [RCW-1:0] RST_INIT  = RCW'(RST_LEN);

  logic [TCW-1:0] trip_cnt;
  logic [RCW-1:0] rst_cnt;
  logic           trip_hit;
  logic           trig;

  assign busy_o   = (rst_cnt != '0);
  assign trip_hit = atrip_i && (trip_cnt == TRIP_LAST);
  assign trig     = vld_i && !busy_o && ar_en_i && (dig_over_i || trip_hit);
  assign flag_o   = busy_o || dig_over_i || atrip_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      trip_cnt <= '0;
    end else if (vld_i) begin
      if (busy_o || !atrip_i || trip_hit) trip_cnt <= '0;
      else                                trip_cnt <= trip_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              rst_cnt <= '0;
    else if (trig)            rst_cnt <= RST_INIT;
    else if (vld_i && busy_o) rst_cnt <= rst_cnt - 1'b1;
  end

  assert_run_clear_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vld_i && !atrip_i) |=> (trip_cnt == '0));

  assert_rst_bound_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_cnt <= RST_INIT);

  assert_rst_needs_en_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(ar_en_i));

  assert_rst_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !vld_i) |=> busy_o);
endmodule

// File: rtl/adc_out_fmt.sv
module adc_out_fmt
  import adc_fmt_pkg::*;
#(
  parameter int DW       = 16,
  parameter int STEP_LOG = 9,
  parameter int TRIP_RUN = 16,
  parameter int RST_LEN  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [REG_AW-1:0] wr_addr_i,
  input  logic [REG_DW-1:0] wr_data_i,
  input  logic [DW-1:0]     sample_i,
  input  logic              sample_vld_i,
  input  logic              atrip_i,
  output logic [DW-1:0]     data_o,
  output logic              dco_o,
  output logic              ovr_o,
  output logic              mod_rst_o
);
  fmt_e             fmt;
  logic             pol;
  logic [THR_W-1:0] thr;
  logic             ar_en;
  logic [DW-1:0]    code;
  logic [DW-1:0]    mid;
  logic             dig_over;
  logic             busy;
  logic             flag;
  logic             dco_q;

  adc_fmt_regs u_regs (
    .clk_i, .rst_ni, .wr_en_i, .wr_addr_i, .wr_data_i,
    .fmt_o(fmt), .pol_o(pol), .thr_o(thr), .ar_en_o(ar_en)
  );

  adc_fmt_code #(.DW(DW), .STEP_LOG(STEP_LOG)) u_code (
    .sample_i, .fmt_i(fmt), .thr_i(thr),
    .code_o(code), .mid_o(mid), .over_o(dig_over)
  );

  adc_ovr_ctrl #(.TRIP_RUN(TRIP_RUN), .RST_LEN(RST_LEN)) u_ctrl (
    .clk_i, .rst_ni, .vld_i(sample_vld_i), .ar_en_i(ar_en),
    .dig_over_i(dig_over), .atrip_i, .busy_o(busy), .flag_o(flag)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_o <= '0;
      ovr_o  <= 1'b0;
      dco_q  <= 1'b0;
    end else begin
      dco_q <= sample_vld_i;
      if (sample_vld_i) begin
        data_o <= busy ? mid : code;
        ovr_o  <= flag;
      end
    end
  end

  assign dco_o     = dco_q ^ pol;
  assign mod_rst_o = busy;

  assert_hold_idle_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sample_vld_i |=> ($stable(data_o) && $stable(ovr_o)));

  assert_flag_in_reset_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mod_rst_o && sample_vld_i) |=> ovr_o);

  assert_trip_flag_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sample_vld_i && atrip_i) |=> ovr_o);

  assert_dco_pulse_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sample_vld_i |=> (dco_o != $past(pol)));
endmodule

// File: tb/adc_out_fmt_test.sv
module adc_out_fmt_test;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic [15:0] sample = '0;
  logic        vld = 1'b0;
  logic        atrip = 1'b0;
  logic [15:0] data;
  logic        dco, ovr, mrst;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  adc_out_fmt uut (
    .clk_i(clk), .rst_ni(rst_ni), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .sample_i(sample), .sample_vld_i(vld), .atrip_i(atrip),
    .data_o(data), .dco_o(dco), .ovr_o(ovr), .mod_rst_o(mrst)
  );

  // {fmt[1:0], thr[5:0], sample[15:0], atrip, exp_data[15:0], exp_ovr}
  localparam int NV = 20;
  localparam logic [41:0] VEC [NV] = '{
    {2'd0, 6'd0,  16'h0000, 1'b0, 16'h8000, 1'b0},
    {2'd1, 6'd0,  16'h1234, 1'b0, 16'h1234, 1'b0},
    {2'd0, 6'd0,  16'hFFFF, 1'b0, 16'h7FFF, 1'b0},
    {2'd2, 6'd0,  16'h0000, 1'b0, 16'hC000, 1'b0},
    {2'd2, 6'd0,  16'h0001, 1'b0, 16'hC001, 1'b0},
    {2'd2, 6'd0,  16'hFFFF, 1'b0, 16'h4000, 1'b0},
    {2'd1, 6'd0,  16'h7FFF, 1'b0, 16'h7FFF, 1'b1},
    {2'd1, 6'd0,  16'h7FFE, 1'b0, 16'h7FFE, 1'b0},
    {2'd1, 6'd0,  16'h8000, 1'b0, 16'h8000, 1'b1},
    {2'd1, 6'd0,  16'h8001, 1'b0, 16'h8001, 1'b1},
    {2'd1, 6'd1,  16'h7DFF, 1'b0, 16'h7DFF, 1'b1},
    {2'd1, 6'd1,  16'h7DFE, 1'b0, 16'h7DFE, 1'b0},
    {2'd1, 6'd1,  16'h8201, 1'b0, 16'h8201, 1'b1},
    {2'd1, 6'd1,  16'h8202, 1'b0, 16'h8202, 1'b0},
    {2'd1, 6'd63, 16'h01FF, 1'b0, 16'h01FF, 1'b1},
    {2'd1, 6'd63, 16'h01FE, 1'b0, 16'h01FE, 1'b0},
    {2'd3, 6'd0,  16'hABCD, 1'b0, 16'hABCD, 1'b0},
    {2'd0, 6'd0,  16'h8000, 1'b0, 16'h0000, 1'b1},
    {2'd1, 6'd0,  16'h0000, 1'b1, 16'h0000, 1'b1},
    {2'd0, 6'd63, 16'h0010, 1'b1, 16'h8010, 1'b1}
  };

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic send(input logic [15:0] s, input logic t);
    @(negedge clk);
    sample = s; vld = 1'b1; atrip = t;
    @(negedge clk);
    vld = 1'b0; atrip = 1'b0;
  endtask

  initial begin
    #(4 * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic seen;
    repeat (3) @(negedge clk);
    chk("R1 data", data, 16'h0000);
    chk("R1 ovr", 16'(ovr), 16'd0);
    chk("R1 dco", 16'(dco), 16'd0);
    chk("R1 rst", 16'(mrst), 16'd0);
    rst_ni = 1'b1;
    send(16'h0000, 1'b0);
    chk("R1 default format", data, 16'h8000);

    for (int i = 0; i < NV; i++) begin
      logic [15:0] hold;
      wr(2'd0, {6'd0, VEC[i][41:40]});
      wr(2'd1, {2'b00, VEC[i][39:34]});
      send(VEC[i][33:18], VEC[i][17]);
      chk("R2 code", data, VEC[i][16:1]);
      chk(VEC[i][17] ? "R5 trip flag" : "R4 threshold", 16'(ovr), 16'(VEC[i][0]));
      chk("R9 dco pulse", 16'(dco), 16'd1);
      hold = data;
      @(negedge clk);
      chk("R3 hold", data, hold);
      chk("R9 dco idle", 16'(dco), 16'd0);
    end

    // R9 inverted polarity
    wr(2'd0, 8'h04);
    send(16'h0000, 1'b0);
    chk("R9 fall pulse", 16'(dco), 16'd0);
    @(negedge clk);
    chk("R9 fall idle", 16'(dco), 16'd1);

    // R10 unmapped writes
    wr(2'd0, 8'h00);
    wr(2'd1, 8'h00);
    wr(2'd2, 8'h02);
    wr(2'd3, 8'h81);
    send(16'h0000, 1'b0);
    chk("R10 format kept", data, 16'h8000);
    send(16'h7FFF, 1'b0);
    chk("R10 threshold kept", 16'(ovr), 16'd1);
    chk("R10 autoreset kept", 16'(mrst), 16'd0);

    // R6 no reset when disabled
    seen = 1'b0;
    for (int i = 0; i < 20; i++) begin
      send(16'h0100, 1'b1);
      seen |= mrst;
    end
    chk("R6 no reset", 16'(seen), 16'd0);
    send(16'h0100, 1'b0);
    chk("R6 follows", 16'(ovr), 16'd0);

    // R7 digital overrange reset, offset binary
    wr(2'd1, 8'h80);
    send(16'h7FFF, 1'b0);
    chk("R7 trigger data", data, 16'hFFFF);
    chk("R7 trigger ovr", 16'(ovr), 16'd1);
    chk("R7 rst rises", 16'(mrst), 16'd1);
    for (int i = 1; i <= 8; i++) begin
      send(16'h0100, 1'b0);
      chk("R7 midscale", data, 16'h8000);
      chk("R7 ovr held", 16'(ovr), 16'd1);
      chk("R7 rst window", 16'(mrst), (i < 8) ? 16'd1 : 16'd0);
    end
    send(16'h0100, 1'b0);
    chk("R7 resume data", data, 16'h8100);
    chk("R7 resume ovr", 16'(ovr), 16'd0);

    // R8 analog run: 15 then break
    for (int i = 0; i < 15; i++) send(16'h0100, 1'b1);
    chk("R8 15 trips ovr", 16'(ovr), 16'd1);
    chk("R8 15 trips no rst", 16'(mrst), 16'd0);
    send(16'h0100, 1'b0);
    chk("R8 break", 16'(ovr), 16'd0);
    wr(2'd0, 8'h02);
    for (int i = 0; i < 15; i++) send(16'h0100, 1'b1);
    chk("R8 run restarted", 16'(mrst), 16'd0);
    send(16'h0100, 1'b1);
    chk("R8 16th trips", 16'(mrst), 16'd1);
    chk("R8 16th data", data, 16'hC180);
    for (int i = 1; i <= 8; i++) begin
      send(16'h0100, 1'b0);
      chk("R7 gray midscale", data, 16'hC000);
      chk("R7 ovr held", 16'(ovr), 16'd1);
    end
    chk("R8 rst done", 16'(mrst), 16'd0);
    send(16'h0100, 1'b0);
    chk("R8 resume", data, 16'hC180);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule